// File: doc/BRIEF.md
# Track Sync Detector and Deinterleaver

This block sits at the receiving end of a 32-bit word bus and rebuilds serial recording tracks from it. Bit i of every accepted word is lane i. One lane, chosen by a static select input, is watched for a frame marker. A marker counts only if a CRC-16 check sequence, placed a configurable number of bytes after it, also verifies. The block works out on its own whether the lanes carry one track each (32-track layout) or two bit-interleaved tracks each (64-track layout). All lanes are assumed to share the frame alignment of the watched lane.

Once locked, every lane is shifted into per-track byte accumulators. In the 64-track layout, the lane bits are split between two tracks by the parity of their position within the frame. Each completed byte is sent out serially, most significant bit first, followed by an odd-parity bit, so each track emits nine bits for every eight it receives. An external enable paces the output, which lets the rate change be made by a clock generator outside the block. At every frame boundary the marker is checked again. If it is missing, the lock is dropped, a one-cycle loss pulse is raised and the search begins again.

Top module: `track_sync_deinterleave`

## Requirements
- R1: While reset is held, and until the first lock, `locked`, `lockLost`, `mode64`, `trackValid` and all of `trackOut` read 0.
- R2: A run of 32 ones on the selected lane starts a 32-track check. The following `gapBytes`*8 lane bits and then 16 CRC bits are fed MSB first through a CRC-16 register that starts at zero, with polynomial x^16+x^15+x^2+1. A zero remainder sets `locked` in the cycle after the word carrying the last CRC bit, with `mode64` = 0.
- R3: A run of 64 ones on the selected lane, which is 32 ones on each interleaved track, selects the 64-track check. Even-indexed lane bits feed the first CRC and odd-indexed bits the second, over 2*(`gapBytes`*8+16) bits. Lock requires both remainders to be zero and sets `mode64` = 1. `mode64` does not change while locked.
- R4: If either track's CRC fails, no lock is taken for that frame, and the search continues with the next frame.
- R5: The CRC field begins exactly `gapBytes`*8 track bits after the end of the marker, so the lock cycle moves with `gapBytes`.
- R6: Only the selected lane is searched and re-checked. A damaged marker on any other lane does not affect `locked` or `lockLost`.
- R7: In 32-track layout, lane i carries track i on `trackOut[i]`, and `trackOut[63:32]` stay 0.
- R8: In 64-track layout, lane i bits at even positions counted from the frame start form track i, and bits at odd positions form track i+32.
- R9: Each track sends eight data bits MSB first followed by one odd-parity bit over them. Bytes are aligned to the frame start, and output begins with the first byte after the CRC of the frame that gave lock. `trackOut` is 0 whenever `trackValid` is 0.
- R10: While `trackValid` is 1, `trackOut` advances one bit on each cycle with `outEn` = 1 and holds otherwise. `trackValid` falls only after a bit is taken with `outEn`.
- R11: While locked, if the last marker bit position of a frame on the selected lane does not complete the expected run of ones, `lockLost` pulses for one cycle, `locked` falls, and a later valid marker and CRC lock again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wordValid | input | 1 | A word is present on `wordIn` this cycle |
| wordIn | input | 32 | One bit per lane |
| selLane | input | 5 | Lane searched for the marker |
| gapBytes | input | GAP_W | Bytes between the marker end and the CRC field |
| outEn | input | 1 | Output bit advance enable from the external rate generator |
| locked | output | 1 | Frame lock held |
| mode64 | output | 1 | Locked layout is 64-track |
| lockLost | output | 1 | One-cycle pulse when the lock is dropped |
| trackValid | output | 1 | `trackOut` carries track bits |
| trackOut | output | 64 | Serial track outputs with parity |

## Verification
The checks assume a well-formed stream. The lane bit just before each marker is 0. No run of 32 ones appears on the watched lane outside a marker. The CRC field fits inside the frame, and `outEn` arrives often enough to drain one byte before the next one is complete. The bench builds its frames to match. Header and payload bytes keep their top bit clear, and the last payload byte of each frame ends in 0. Markers are damaged only in controlled frames. `outEn` drops on one cycle in four, and words arrive every other cycle, so output always outpaces input.

// File: rtl/tsd_pkg.sv
package tsd_pkg;
  typedef struct packed {
    logic collect;   // accept lane bits into accumulators
    logic phase;     // 1 selects the odd (upper) track bank
    logic byteDone;  // this bit completes a byte on every active track
    logic is64;      // locked layout is 64-track
  } dpCtl_t;
endpackage

// File: rtl/tsd_sync_ctrl.sv
module tsd_sync_ctrl #(
  parameter int LANES      = 32,
  parameter int FRAME_BITS = 20160,
  parameter int GAP_W      = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     wordValid,
  input  logic [LANES-1:0]         wordIn,
  input  logic [$clog2(LANES)-1:0] selLane,
  input  logic [GAP_W-1:0]         gapBytes,
  output tsd_pkg::dpCtl_t          ctl,
  output logic                     locked,
  output logic                     mode64,
  output logic                     lockLost
);
  localparam int SYNC_BITS = 32;
  localparam int CRC_BITS  = 16;
  localparam int WIN       = 2 * SYNC_BITS;
  localparam int FPW       = $clog2(2 * FRAME_BITS + 1);
  localparam int VCW       = $clog2(2 * (CRC_BITS + 8 * (2 ** GAP_W)) + 1);
  localparam logic [CRC_BITS-1:0] POLY = 16'h8005;

  typedef enum logic [1:0] {SEARCH, VERIFY, LOCK} state_t;

  function automatic logic [CRC_BITS-1:0] crcStep(input logic [CRC_BITS-1:0] c, input logic b);
    crcStep = {c[CRC_BITS-2:0], 1'b0} ^ ((c[CRC_BITS-1] ^ b) ? POLY : '0);
  endfunction

  state_t state;
  logic [WIN-1:0] win, winNext;
  logic laneBit, syncLong, syncShort;
  logic vMode64, is64, useB, pass;
  logic [VCW-1:0] vCnt, trackGather, gatherLen;
  logic [FPW-1:0] fpos, trackLock, lockPos, frameLast, syncEnd;
  logic [CRC_BITS-1:0] crcA, crcB, crcNextA, crcNextB;

  always_comb begin
    laneBit     = wordIn[selLane];
    winNext     = {win[WIN-2:0], laneBit};
    syncLong    = &winNext;
    syncShort   = &winNext[SYNC_BITS-1:0];
    trackGather = VCW'(CRC_BITS) + (VCW'(gapBytes) << 3);
    gatherLen   = vMode64 ? (trackGather << 1) : trackGather;
    trackLock   = FPW'(SYNC_BITS + CRC_BITS) + (FPW'(gapBytes) << 3);
    lockPos     = vMode64 ? (trackLock << 1) : trackLock;
    frameLast   = is64 ? FPW'(2 * FRAME_BITS - 1) : FPW'(FRAME_BITS - 1);
    syncEnd     = is64 ? FPW'(2 * SYNC_BITS - 1) : FPW'(SYNC_BITS - 1);
    crcNextA    = crcStep(crcA, laneBit);
    crcNextB    = crcStep(crcB, laneBit);
    useB        = vMode64 & vCnt[0];
    pass        = vMode64 ? (crcNextB == '0 && crcA == '0) : (crcNextA == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= SEARCH;
      win      <= '0;
      vMode64  <= 1'b0;
      vCnt     <= '0;
      crcA     <= '0;
      crcB     <= '0;
      is64     <= 1'b0;
      fpos     <= '0;
      lockLost <= 1'b0;
    end else begin
      lockLost <= 1'b0;
      if (wordValid) begin
        win <= winNext;
        case (state)
          SEARCH: begin
            if (syncLong || syncShort) begin
              state   <= VERIFY;
              vMode64 <= syncLong;
              vCnt    <= '0;
              crcA    <= '0;
              crcB    <= '0;
            end
          end
          VERIFY: begin
            if (!vMode64 && syncLong) begin
              // second interleaved marker completed: restart as 64-track
              vMode64 <= 1'b1;
              vCnt    <= '0;
              crcA    <= '0;
              crcB    <= '0;
            end else begin
              if (useB) crcB <= crcNextB;
              else      crcA <= crcNextA;
              vCnt <= vCnt + 1'b1;
              if (vCnt == gatherLen - 1'b1) begin
                if (pass) begin
                  state <= LOCK;
                  is64  <= vMode64;
                  fpos  <= lockPos;
                end else begin
                  state <= SEARCH;
                end
              end
            end
          end
          LOCK: begin
            fpos <= (fpos == frameLast) ? '0 : fpos + 1'b1;
            if (fpos == syncEnd && !(is64 ? syncLong : syncShort)) begin
              state    <= SEARCH;
              lockLost <= 1'b1;
            end
          end
          default: state <= SEARCH;
        endcase
      end
    end
  end

  assign locked       = (state == LOCK);
  assign mode64       = is64;
  assign ctl.collect  = locked & wordValid;
  assign ctl.phase    = is64 & fpos[0];
  assign ctl.byteDone = ctl.collect & (is64 ? (fpos[3:0] == 4'hF) : (fpos[2:0] == 3'h7));
  assign ctl.is64     = is64;
endmodule

// File: rtl/tsd_track_dp.sv
module tsd_track_dp #(
  parameter int LANES = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  tsd_pkg::dpCtl_t    ctl,
  input  logic [LANES-1:0]   wordIn,
  input  logic               outEn,
  output logic               trackValid,
  output logic [2*LANES-1:0] trackOut
);
  localparam int BYTE_BITS = 8;
  localparam int SER_BITS  = BYTE_BITS + 1;
  localparam logic [3:0] LAST_BIT = 4'(SER_BITS - 1);

  logic holdFull, shValid, loadSh, shiftEn;
  logic [3:0] outCnt;

  assign loadSh  = holdFull & (~shValid | (outEn & (outCnt == LAST_BIT)));
  assign shiftEn = outEn & shValid & (outCnt != LAST_BIT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdFull <= 1'b0;
      shValid  <= 1'b0;
      outCnt   <= '0;
    end else begin
      if (ctl.byteDone)  holdFull <= 1'b1;
      else if (loadSh)   holdFull <= 1'b0;
      if (loadSh) begin
        shValid <= 1'b1;
        outCnt  <= '0;
      end else if (outEn && shValid) begin
        if (outCnt == LAST_BIT) shValid <= 1'b0;
        else                    outCnt  <= outCnt + 1'b1;
      end
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [BYTE_BITS-1:0] accLo, accHi, accNextLo, accNextHi, holdLo, holdHi;
    logic [SER_BITS-1:0]  shLo, shHi;

    assign accNextLo = {accLo[BYTE_BITS-2:0], wordIn[i]};
    assign accNextHi = {accHi[BYTE_BITS-2:0], wordIn[i]};

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        accLo  <= '0;
        accHi  <= '0;
        holdLo <= '0;
        holdHi <= '0;
        shLo   <= '0;
        shHi   <= '0;
      end else begin
        if (ctl.collect) begin
          if (ctl.phase) accHi <= accNextHi;
          else           accLo <= accNextLo;
        end
        if (ctl.byteDone) begin
          holdLo <= ctl.is64 ? accLo : accNextLo;
          holdHi <= accNextHi;
        end
        if (loadSh) begin
          shLo <= {holdLo, ~^holdLo};
          shHi <= {holdHi, ~^holdHi};
        end else if (shiftEn) begin
          shLo <= {shLo[SER_BITS-2:0], 1'b0};
          shHi <= {shHi[SER_BITS-2:0], 1'b0};
        end
      end
    end

    assign trackOut[i]         = shValid & shLo[SER_BITS-1];
    assign trackOut[i + LANES] = shValid & ctl.is64 & shHi[SER_BITS-1];
  end

  assign trackValid = shValid;
endmodule

// File: rtl/track_sync_deinterleave.sv
module track_sync_deinterleave #(
  parameter int FRAME_BITS = 20160,
  parameter int GAP_W      = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wordValid,
  input  logic [31:0]      wordIn,
  input  logic [4:0]       selLane,
  input  logic [GAP_W-1:0] gapBytes,
  input  logic             outEn,
  output logic             locked,
  output logic             mode64,
  output logic             lockLost,
  output logic             trackValid,
  output logic [63:0]      trackOut
);
  localparam int LANES = 32;

  tsd_pkg::dpCtl_t ctl;

  tsd_sync_ctrl #(.LANES(LANES), .FRAME_BITS(FRAME_BITS), .GAP_W(GAP_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wordValid(wordValid), .wordIn(wordIn),
    .selLane(selLane), .gapBytes(gapBytes), .ctl(ctl),
    .locked(locked), .mode64(mode64), .lockLost(lockLost));

  tsd_track_dp #(.LANES(LANES)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wordIn(wordIn), .outEn(outEn),
    .trackValid(trackValid), .trackOut(trackOut));
endmodule

// File: rtl/tsd_checker.sv
module tsd_checker (
  input logic        clk,
  input logic        rstN,
  input logic        wordValid,
  input logic        outEn,
  input logic        locked,
  input logic        mode64,
  input logic        lockLost,
  input logic        trackValid,
  input logic [63:0] trackOut
);
  p_loss_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    lockLost |-> (!locked && $past(locked)));
  p_lock_on_word_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(locked) |-> $past(wordValid));
  p_mode_steady_r3: assert property (@(posedge clk) disable iff (!rstN)
    (locked && $past(locked)) |-> $stable(mode64));
  p_upper_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    !mode64 |-> (trackOut[63:32] == '0));
  p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    !trackValid |-> (trackOut == '0));
  p_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (trackValid && !outEn) |=> (trackValid && $stable(trackOut[31:0])));
  p_drain_r10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(trackValid) |-> $past(outEn));
endmodule

bind track_sync_deinterleave tsd_checker u_chk (
  .clk(clk), .rstN(rstN), .wordValid(wordValid), .outEn(outEn),
  .locked(locked), .mode64(mode64), .lockLost(lockLost),
  .trackValid(trackValid), .trackOut(trackOut));

// File: tb/track_sync_deinterleave_test.sv
`timescale 1ns/1ps
module track_sync_deinterleave_test;
  localparam int FRAME_BITS = 128;
  localparam int FB = FRAME_BITS / 8;
  localparam int MAXREC = 1024;

  logic clk = 0, rstN = 0, wordValid = 0, outEn = 0;
  logic [31:0] wordIn = '0;
  logic [4:0] selLane = '0;
  logic [3:0] gapBytes = '0;
  logic locked, mode64, lockLost, trackValid;
  logic [63:0] trackOut;

  int errors = 0, checks = 0;
  int gapG = 0, modeM = 1, selG = 0, badCrcTrack = -1, badSyncFrame = -1, badSyncKind = 0;
  int recN = 0, lostSeen = 0, cyc = 0;
  bit recOn = 0;
  logic [63:0] rec [0:MAXREC-1];

  track_sync_deinterleave #(.FRAME_BITS(FRAME_BITS), .GAP_W(4)) uut (
    .clk(clk), .rstN(rstN), .wordValid(wordValid), .wordIn(wordIn),
    .selLane(selLane), .gapBytes(gapBytes), .outEn(outEn),
    .locked(locked), .mode64(mode64), .lockLost(lockLost),
    .trackValid(trackValid), .trackOut(trackOut));

  always #2.5 clk = ~clk;

  initial forever begin
    @(posedge clk); #1;
    cyc++;
    outEn = (cyc % 4 != 3);
  end

  always @(negedge clk) begin
    if (lockLost) lostSeen++;
    if (recOn && outEn && trackValid && recN < MAXREC) begin
      rec[recN] = trackOut;
      recN++;
    end
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
    $finish;
  end

  task automatic check(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic bit syncHit(int t);
    if (badSyncKind == 1) return 1;
    if (badSyncKind == 2) return (t != selG) && !(modeM == 2 && t == selG + 32);
    return 0;
  endfunction

  function automatic logic [7:0] hdrByte(int t, int f, int b);
    return 8'((f * 13 + t * 7 + b * 5) & 127);
  endfunction

  function automatic logic [15:0] crcOf(int t, int f);
    logic [15:0] c = '0;
    for (int b = 4; b < 4 + gapG; b++) begin
      logic [7:0] v = hdrByte(t, f, b);
      for (int k = 7; k >= 0; k--)
        c = {c[14:0], 1'b0} ^ ((c[15] ^ v[k]) ? 16'h8005 : 16'h0000);
    end
    return c;
  endfunction

  function automatic logic [7:0] rawByte(int t, int f, int b);
    logic [15:0] c;
    if (b < 4) return (f == badSyncFrame && b == 0 && syncHit(t)) ? 8'hF7 : 8'hFF;
    if (b < 4 + gapG) return hdrByte(t, f, b);
    if (b < 6 + gapG) begin
      c = crcOf(t, f);
      if (t == badCrcTrack) c = c ^ 16'h0001;
      return (b == 4 + gapG) ? c[15:8] : c[7:0];
    end
    if (b == FB - 1) return 8'((f * 29 + t * 3 + b * 17) & 126);
    return 8'((f * 29 + t * 3 + b * 17) & 127);
  endfunction

  function automatic logic trackBit(int t, int f, int n);
    logic [7:0] v = rawByte(t, f, n / 8);
    return v[7 - (n % 8)];
  endfunction

  task automatic sendWord(input logic [31:0] w);
    @(posedge clk); #1;
    wordValid = 1; wordIn = w;
    @(posedge clk); #1;
    wordValid = 0;
  endtask

  task automatic sendFrame(input int f, input bit chk);
    int lockIdx = (48 + 8 * gapG) * modeM - 1;
    for (int n = 0; n < FRAME_BITS * modeM; n++) begin
      logic [31:0] w;
      for (int i = 0; i < 32; i++)
        w[i] = (modeM == 1) ? trackBit(i, f, n) : trackBit((n % 2) ? i + 32 : i, f, n / 2);
      sendWord(w);
      if (chk && n == lockIdx - 1)
        check(locked == 0, "R5 no lock before last CRC bit", locked, 0);
      if (chk && n == lockIdx) begin
        if (modeM == 1) check(locked && !mode64, "R2 R5 32-track lock", {locked, mode64}, 2'b10);
        else            check(locked && mode64, "R3 R5 64-track lock", {locked, mode64}, 2'b11);
      end
    end
  endtask

  task automatic startRun(input int m, input int gap, input int sel);
    rstN = 0; wordValid = 0; wordIn = '0;
    modeM = m; gapG = gap; selG = sel;
    selLane = 5'(sel); gapBytes = 4'(gap);
    badCrcTrack = -1; badSyncFrame = -1; badSyncKind = 0;
    recOn = 0; recN = 0; lostSeen = 0;
    repeat (3) @(negedge clk);
    check(!locked && !lockLost && !mode64 && !trackValid && trackOut == '0,
          "R1 reset state", {locked, lockLost, mode64, trackValid, |trackOut}, 0);
    @(posedge clk); #1;
    rstN = 1; recOn = 1;
    repeat (3) sendWord('0);
  endtask

  task automatic compareData(input int f0, input int lastFrame);
    int startB = 6 + gapG;
    int nBits = (FB * (lastFrame + 1 - f0) - startB) * 9;
    int badData = 0, badPar = 0, badUpper = 0;
    repeat (80) @(posedge clk);
    check(recN >= nBits, "R9 R10 output bit count", recN, nBits);
    for (int j = 0; j < nBits && j < recN; j++) begin
      int gb = startB + j / 9;
      int r = j % 9;
      for (int t = 0; t < 64; t++) begin
        logic [7:0] v;
        logic e;
        if (modeM == 1 && t >= 32) begin
          if (rec[j][t] !== 1'b0) badUpper++;
        end else begin
          v = rawByte(t, f0 + gb / FB, gb % FB);
          e = (r < 8) ? v[7 - r] : ~(^v);
          if (rec[j][t] !== e) begin
            if (r < 8) badData++;
            else       badPar++;
          end
        end
      end
    end
    if (modeM == 1) begin
      check(badData == 0, "R7 R10 32-track data bits", badData, 0);
      check(badUpper == 0, "R7 upper tracks quiet", badUpper, 0);
    end else begin
      check(badData == 0, "R8 R10 64-track deinterleaved data", badData, 0);
    end
    check(badPar == 0, "R9 odd parity bits", badPar, 0);
  endtask

  task automatic runNormal(input int m, input int gap, input int sel, input int lossKind);
    startRun(m, gap, sel);
    if (lossKind != 0) begin
      badSyncFrame = 4;
      badSyncKind = lossKind;
    end
    sendFrame(0, 1);
    for (int f = 1; f < 4; f++) sendFrame(f, 0);
    if (lossKind == 1) begin
      sendFrame(4, 0);
      check(lostSeen == 1 && !locked, "R11 lock dropped on missing marker", {lostSeen, locked}, 2);
      sendFrame(5, 1);
      check(locked == 1, "R11 search restarts and relocks", locked, 1);
    end else if (lossKind == 2) begin
      sendFrame(4, 0);
      check(lostSeen == 0 && locked, "R6 other lanes ignored", {lostSeen, locked}, 1);
    end
    compareData(0, 3);
  endtask

  task automatic runBadCrc(input int m, input int gap, input int sel);
    startRun(m, gap, sel);
    badCrcTrack = (m == 1) ? sel : sel + 32;
    sendFrame(0, 0);
    check(locked == 0, "R4 CRC mismatch gives no lock", locked, 0);
    badCrcTrack = -1;
    sendFrame(1, 1);
    sendFrame(2, 0);
    sendFrame(3, 0);
    compareData(1, 3);
  endtask

  initial begin
    runNormal(1, 0, 3, 0);
    runNormal(1, 1, 0, 1);
    runNormal(1, 3, 31, 2);
    runNormal(2, 0, 17, 1);
    runNormal(2, 2, 5, 2);
    runNormal(2, 3, 0, 0);
    runBadCrc(1, 2, 9);
    runBadCrc(2, 1, 22);
    summary();
    $finish;
  end
endmodule